// File: doc/BRIEF.md
# Coefficient Bank Loader

The block loads filter coefficient sets into a small on-chip bank and presents one stored set to the filter. Coefficient bytes arrive on an 8-bit port under an active-low load strobe. Each load sequence is a fixed run of consecutive bytes, one per clock while the strobe stays LOW. The sequence is committed to the bank slot named by an internal write pointer, and a one-cycle done pulse follows. A load starts only on a HIGH-to-LOW edge of the strobe. A strobe that is held LOW from reset, or that stays LOW after a finished load, writes nothing until it has been seen HIGH again.

A separate 8-bit address register, written through an active-low enable, picks the active set. Its low bits index the bank. The selected set is driven combinationally from the bank registers as one flat vector.

If the strobe returns HIGH before the last byte, the partial set is thrown away. The target slot and the write pointer are left as they were.

Top module: `cfl_coef_loader`

## Requirements
- R1: After reset the active set output is all zeros, the done pulse is low, the address register reads 0 and every bank slot holds 0.
- R2: When armed, each clock edge with the strobe LOW captures one byte. After WORDS (default 4) consecutive LOW edges the set is written to the bank, and the done output is 1 for exactly the cycle that follows that edge.
- R3: After reset the loader is not armed. A strobe held LOW from reset captures nothing and raises no done pulse until it has been sampled HIGH.
- R4: After a completed sequence, a strobe that stays LOW starts no new sequence and raises no further done pulse.
- R5: A strobe sampled HIGH before the last byte ends the sequence. The target slot keeps its old contents, and the next complete sequence goes to that same slot.
- R6: While the strobe is HIGH, no coefficient byte is captured, and the bank does not change.
- R7: A clock edge with the address enable LOW latches the 8-bit address input into the address register.
- R8: While the address enable is HIGH, the address register keeps its value.
- R9: The active set is the bank slot given by the low log2(SETS) bits of the address register, and the upper address bits are ignored. The byte captured k-th in a sequence appears at bits [8k+7:8k].
- R10: The write pointer starts at slot 0. It advances by one after each completed sequence and wraps from SETS-1 (default 3) back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_n | input | 1 | Active-low coefficient load strobe |
| coef_in | input | 8 | Coefficient byte |
| addr_en_n | input | 1 | Active-low address register write enable |
| addr_in | input | 8 | Coefficient set address |
| coef_set_o | output | 32 | Active coefficient set, byte k at bits [8k+7:8k] |
| addr_o | output | 8 | Current address register contents |
| load_done_o | output | 1 | One-cycle pulse after a completed set |

## Verification
On every cycle, the assertions check the following:
- an unarmed LOW strobe starts no sequence;
- the done pulse lasts one cycle and follows a LOW strobe;
- the bank changes only on a commit;
- the address register follows its enable.

Only the directed scenarios can show the remaining behaviour: which bytes land in which slot and in what order, that an abort leaves the old contents in place, that the write pointer wraps, and that the high address bits have no effect on the selected set.

// File: rtl/cfl_pkg.sv
package cfl_pkg;
  typedef enum logic {
    LD_IDLE = 1'b0,
    LD_RUN  = 1'b1
  } ld_state_e;
endpackage

// File: rtl/cfl_rst_sync.sv
module cfl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/cfl_addr_reg.sv
module cfl_addr_reg #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q
);
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    addr_d = addr_q;
    if (!en_n) addr_d = addr_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  AST_ADDR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !en_n |=> addr_q == $past(addr_in)); // R7
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> $stable(addr_q)); // R8
endmodule

// File: rtl/cfl_load_ctrl.sv
module cfl_load_ctrl
  import cfl_pkg::*;
#(
  parameter int WORDS = 4,
  parameter int SETS  = 4,
  localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int SLOT_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  output logic              cap_en,
  output logic [IDX_W-1:0]  cap_idx,
  output logic              commit,
  output logic [SLOT_W-1:0] wr_slot,
  output logic              done_q
);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(WORDS - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SETS - 1);

  ld_state_e         state_q, state_d;
  logic              armed_q, armed_d;
  logic [IDX_W-1:0]  cnt_q, cnt_d;
  logic [SLOT_W-1:0] wptr_q, wptr_d;

  always_comb begin
    state_d = state_q;
    armed_d = armed_q;
    cnt_d   = cnt_q;
    wptr_d  = wptr_q;
    cap_en  = 1'b0;
    cap_idx = cnt_q;
    commit  = 1'b0;
    unique case (state_q)
      LD_IDLE: begin
        if (load_n) begin
          armed_d = 1'b1;
        end else if (armed_q) begin
          cap_en  = 1'b1;
          cap_idx = '0;
          armed_d = 1'b0;
          cnt_d   = IDX_W'(1);
          state_d = LD_RUN;
        end
      end
      LD_RUN: begin
        if (load_n) begin
          armed_d = 1'b1;
          cnt_d   = '0;
          state_d = LD_IDLE;
        end else begin
          cap_en = 1'b1;
          if (cnt_q == LAST_IDX) begin
            commit  = 1'b1;
            cnt_d   = '0;
            state_d = LD_IDLE;
            wptr_d  = (wptr_q == LAST_SLOT) ? '0 : wptr_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: state_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      wptr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      wptr_q  <= wptr_d;
      done_q  <= commit;
    end
  end

  assign wr_slot = wptr_q;

  AST_NO_UNARMED_START: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == LD_IDLE && !armed_q && !load_n) |=> state_q == LD_IDLE); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R2
  AST_DONE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> !$past(load_n)); // R2
  AST_HIGH_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> !done_q); // R6
endmodule

// File: rtl/cfl_bank.sv
module cfl_bank #(
  parameter int WORD_W = 8,
  parameter int WORDS  = 4,
  parameter int SETS   = 4,
  localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int SLOT_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap_en,
  input  logic [IDX_W-1:0]        cap_idx,
  input  logic [WORD_W-1:0]       cap_data,
  input  logic                    commit,
  input  logic [SLOT_W-1:0]       wr_slot,
  input  logic [SLOT_W-1:0]       rd_slot,
  output logic [WORDS*WORD_W-1:0] rd_set
);
  logic [WORDS-1:0][WORD_W-1:0]           stage_q, stage_d;
  logic [SETS-1:0][WORDS-1:0][WORD_W-1:0] bank_q, bank_d;

  always_comb begin
    stage_d = stage_q;
    if (cap_en) stage_d[cap_idx] = cap_data;
  end

  generate
    for (genvar s = 0; s < SETS; s++) begin : g_slot
      always_comb begin
        bank_d[s] = bank_q[s];
        if (commit && wr_slot == SLOT_W'(s)) bank_d[s] = stage_d;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      bank_q  <= '0;
    end else begin
      stage_q <= stage_d;
      bank_q  <= bank_d;
    end
  end

  assign rd_set = bank_q[rd_slot];

  AST_BANK_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(bank_q)); // R5
  AST_COMMIT_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> cap_en); // R2
endmodule

// File: rtl/cfl_coef_loader.sv
module cfl_coef_loader #(
  parameter int WORD_W = 8,
  parameter int ADDR_W = 8,
  parameter int WORDS  = 4,
  parameter int SETS   = 4,
  localparam int IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int SLOT_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_n,
  input  logic [WORD_W-1:0]       coef_in,
  input  logic                    addr_en_n,
  input  logic [ADDR_W-1:0]       addr_in,
  output logic [WORDS*WORD_W-1:0] coef_set_o,
  output logic [ADDR_W-1:0]       addr_o,
  output logic                    load_done_o
);
  logic              rst_n_s;
  logic              cap_en;
  logic [IDX_W-1:0]  cap_idx;
  logic              commit;
  logic [SLOT_W-1:0] wr_slot;

  cfl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  cfl_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .en_n    (addr_en_n),
    .addr_in (addr_in),
    .addr_q  (addr_o)
  );

  cfl_load_ctrl #(.WORDS(WORDS), .SETS(SETS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load_n  (load_n),
    .cap_en  (cap_en),
    .cap_idx (cap_idx),
    .commit  (commit),
    .wr_slot (wr_slot),
    .done_q  (load_done_o)
  );

  cfl_bank #(.WORD_W(WORD_W), .WORDS(WORDS), .SETS(SETS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .cap_en   (cap_en),
    .cap_idx  (cap_idx),
    .cap_data (coef_in),
    .commit   (commit),
    .wr_slot  (wr_slot),
    .rd_slot  (addr_o[SLOT_W-1:0]),
    .rd_set   (coef_set_o)
  );
endmodule

// File: tb/sim_cfl_coef_loader.sv
module sim_cfl_coef_loader;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load_n;
  logic [7:0]  coef_in;
  logic        addr_en_n;
  logic [7:0]  addr_in;
  logic [31:0] coef_set_o;
  logic [7:0]  addr_o;
  logic        load_done_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  cfl_coef_loader u0 (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .coef_in(coef_in),
    .addr_en_n(addr_en_n), .addr_in(addr_in), .coef_set_o(coef_set_o),
    .addr_o(addr_o), .load_done_o(load_done_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic sel_addr(input logic [7:0] a);
    @(negedge clk); addr_en_n = 1'b0; addr_in = a;
    @(negedge clk); addr_en_n = 1'b1;
  endtask

  // Arm, send four bytes, then optionally keep the strobe LOW.
  task automatic load_set(input logic [31:0] w, input bit keep_low);
    @(negedge clk); load_n = 1'b1;
    @(negedge clk); load_n = 1'b0; coef_in = w[7:0];
    for (int k = 1; k < 4; k++) begin
      @(negedge clk); coef_in = w[8*k +: 8];
      check("R2 no early done", {31'b0, load_done_o}, 32'h0);
    end
    @(negedge clk);
    check("R2 done pulse", {31'b0, load_done_o}, 32'h1);
    if (!keep_low) load_n = 1'b1;
    @(negedge clk);
    check("R2 done one cycle", {31'b0, load_done_o}, 32'h0);
  endtask

  task automatic t_reset;
    check("R1 set zero", coef_set_o, 32'h0);
    check("R1 done low", {31'b0, load_done_o}, 32'h0);
    check("R1 addr zero", {24'b0, addr_o}, 32'h0);
  endtask

  task automatic t_unarmed;
    int seen = 0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); coef_in = 8'h50 + 8'(k);
      if (load_done_o) seen++;
    end
    check("R3 no done while unarmed", 32'(seen), 32'h0);
    check("R3 slot0 untouched", coef_set_o, 32'h0);
    for (int k = 0; k < 4; k++) begin
      sel_addr(8'(k));
      check("R1 bank slot zero", coef_set_o, 32'h0);
    end
    sel_addr(8'h00);
  endtask

  task automatic t_load;
    load_set(32'h44332211, 1'b0);
    check("R9 slot0 byte order", coef_set_o, 32'h44332211);
    sel_addr(8'h01);
    check("R7 addr latched", {24'b0, addr_o}, 32'h01);
    check("R10 slot1 empty", coef_set_o, 32'h0);
    load_set(32'hA5B6C7D8, 1'b0);
    check("R10 second load to slot1", coef_set_o, 32'hA5B6C7D8);
    sel_addr(8'h00);
    check("R10 slot0 kept", coef_set_o, 32'h44332211);
  endtask

  task automatic t_hold_low;
    int seen = 0;
    load_set(32'h0F0E0D0C, 1'b1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); coef_in = 8'hE0 + 8'(k);
      if (load_done_o) seen++;
    end
    check("R4 no restart while LOW", 32'(seen), 32'h0);
    load_n = 1'b1;
    sel_addr(8'h02);
    check("R2 slot2 loaded", coef_set_o, 32'h0F0E0D0C);
    sel_addr(8'h03);
    check("R4 slot3 untouched", coef_set_o, 32'h0);
  endtask

  task automatic t_abort;
    @(negedge clk); load_n = 1'b1;
    @(negedge clk); load_n = 1'b0; coef_in = 8'h99;
    @(negedge clk); coef_in = 8'h98;
    @(negedge clk); load_n = 1'b1; coef_in = 8'h97;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R6 no done while HIGH", {31'b0, load_done_o}, 32'h0);
    end
    check("R5 slot3 kept after abort", coef_set_o, 32'h0);
    load_set(32'h13579BDF, 1'b0);
    check("R5 retry lands in slot3", coef_set_o, 32'h13579BDF);
  endtask

  task automatic t_addr_hold;
    @(negedge clk); addr_en_n = 1'b1; addr_in = 8'h01;
    @(negedge clk); addr_in = 8'h02;
    @(negedge clk);
    check("R8 addr held", {24'b0, addr_o}, 32'h03);
    check("R8 set held", coef_set_o, 32'h13579BDF);
  endtask

  task automatic t_wrap;
    load_set(32'hCAFEF00D, 1'b0);
    sel_addr(8'hF0);
    check("R10 wrap to slot0", coef_set_o, 32'hCAFEF00D);
    sel_addr(8'hF1);
    check("R9 high addr bits ignored", coef_set_o, 32'hA5B6C7D8);
    check("R7 full addr stored", {24'b0, addr_o}, 32'hF1);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_n = 1'b0; coef_in = 8'h00;
    addr_en_n = 1'b1; addr_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_unarmed();
    t_load();
    t_hold_low();
    t_abort();
    t_addr_hold();
    t_wrap();
    report();
    $finish;
  end
endmodule